// File: doc/BRIEF.md
# Phase-Interleaved CPU/Video DRAM Arbiter

This block lets a processor and a display fetch unit share one DRAM array without either of them ever being held off. Time is cut into slots of a fixed number of master-clock ticks. A slower "fast clock" level, produced by the block itself, flips at the end of every slot. While that level is low the processor owns the array, and while it is high the video fetch owns it. No request or grant exchange takes place. The level itself steers the address multiplexer. Inside each slot the block presents the row half of the owner's address with the row strobe, then the column half with the column strobe. It captures the returned data on a fixed tick and then precharges.

The array is built from two 8-bit banks. In the normal mode the lowest address bit picks one bank, and only that bank sees a column strobe. In the wide mode the video slot strobes both banks at the same row and column and returns 16 bits at once, which doubles the display bandwidth. Processor slots always use one bank. No refresh logic exists: every slot opens a row, so a display scan that visits every row within the retention interval keeps the array refreshed. Processor read data stays in a holding register from the end of one processor slot until the next one updates it.

Top module: `vidcpu_interleave_arb`

## Requirements
- R1: After reset the first slot belongs to the processor. Ownership then alternates every SLOT_TICKS ticks. `fclk_o` is 0 in processor slots and 1 in video slots.
- R2: Address bit 0 selects the bank, bits [RW:1] form the column and bits [2*RW:RW+1] form the row. In tick 0 of a slot `dram_a` carries the owner's row, and from tick 1 on it carries the owner's column. The owner is chosen by the `fclk_o` level.
- R3: `dram_ras_n` is low in ticks 0 to 2 of every slot. Column strobes are low only in ticks 1 and 2. From tick 3 to the end of the slot all strobes are high (precharge).
- R4: `dram_we_n` goes low only in ticks 1 and 2 of a processor slot in which `cpu_we` is 1. Video slots never write.
- R5: In processor slots, and in video slots in normal mode, exactly one column strobe is active: `dram_cas_n[0]` when address bit 0 is 0, `dram_cas_n[1]` when it is 1.
- R6: In wide mode a video slot drives both column strobes low. `vid_rdata` then becomes {bank 1 byte, bank 0 byte} at the same row and column, and bit 0 of the video address is ignored.
- R7: In normal mode `vid_rdata` becomes {8'h00, byte of the selected bank}.
- R8: On a processor read, `cpu_rdata` takes the selected byte at the end of tick 2. It then holds until the next processor read captures. A processor write leaves it unchanged.
- R9: Every video slot opens a row cycle on the video address's row, so the display scan also serves as refresh.
- R10: While reset is held, all strobes are high, `fclk_o` is 0 and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2*RW+1 | Processor address, held stable through its slot |
| cpu_we | input | 1 | Processor write request for the current slot |
| cpu_wdata | input | DW | Processor write data |
| vid_addr | input | 2*RW+1 | Video fetch address, held stable through its slot |
| wide_mode | input | 1 | 1 selects dual-bank video fetch |
| fclk_o | output | 1 | Slot owner level: 0 processor, 1 video |
| dram_a | output | RW | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, shared by both banks |
| dram_cas_n | output | 2 | Column strobe per bank |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | DW | Write data toward the array |
| dram_dq_i | input | 2*DW | Read data, bank 1 in the upper byte |
| cpu_rdata | output | DW | Held processor read data |
| vid_rdata | output | 2*DW | Video read data |

## Verification
With the default four-tick slot, each result is due at a fixed offset from the start of a processor slot. The processor row is on `dram_a` at offset 0. The column and strobes appear at offset 1, precharge at offset 3, and `cpu_rdata` is valid at offset 3. The video row appears at offset 4, the video strobes at offset 5, and `vid_rdata` is valid at offset 7. The bench locks onto the falling edge of `fclk_o` once and changes inputs at a slot start. It then samples on falling clock edges at exactly those offsets, so each value is read in the tick it is due. A directed test also samples `cpu_rdata` in ticks 0 to 2 of the following processor slot, to show the old value is held until the new capture.

// File: rtl/mil_pkg.sv
package mil_pkg;
  // fixed tick positions inside a slot
  localparam int ROW_TICK  = 0;
  localparam int CAS_FIRST = 1;
  localparam int CAP_TICK  = 2;
  localparam int PRE_TICK  = 3;
  localparam int MIN_SLOT  = 4;

  function automatic logic [1:0] bank_onehot(input logic sel);
    return sel ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/mil_slot_timer.sv
module mil_slot_timer #(
  parameter int SLOT_TICKS = 4,
  localparam int TW = $clog2(SLOT_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rst_sync_n,
  output logic          run,
  output logic [TW-1:0] tick,
  output logic          fclk
);
  localparam logic [TW-1:0] LAST = TW'(SLOT_TICKS - 1);

  logic [1:0]    sync_q;
  logic          run_q, run_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          fclk_q, fclk_d;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    run_d  = 1'b1;
    tick_d = tick_q;
    fclk_d = fclk_q;
    if (run_q) begin
      if (tick_q == LAST) begin
        tick_d = '0;
        fclk_d = ~fclk_q;
      end else begin
        tick_d = tick_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      fclk_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (run_q) begin
        tick_q <= tick_d;
        fclk_q <= fclk_d;
      end
    end
  end

  assign run  = run_q;
  assign tick = tick_q;
  assign fclk = fclk_q;

  // R1: owner level flips exactly at slot ends
  assert_slot_flip_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && tick_q == LAST) |=> (fclk_q != $past(fclk_q)));
  assert_slot_hold_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_q != LAST) |=> $stable(fclk_q));
endmodule

// File: rtl/mil_addr_mux.sv
module mil_addr_mux #(
  parameter int RW = 4,
  parameter int TW = 2,
  localparam int AW = 2 * RW + 1
) (
  input  logic          fclk,
  input  logic [TW-1:0] tick,
  input  logic          wide,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] vid_addr,
  output logic [RW-1:0] dram_a,
  output logic [1:0]    bank_en
);
  import mil_pkg::*;

  logic [AW-1:0] src;

  always_comb begin
    // the owner level itself selects the source
    src = fclk ? vid_addr : cpu_addr;
    if (tick == TW'(ROW_TICK)) dram_a = src[2*RW:RW+1];
    else                       dram_a = src[RW:1];
    if (fclk && wide) bank_en = 2'b11;
    else              bank_en = bank_onehot(src[0]);
  end
endmodule

// File: rtl/mil_strobe_gen.sv
module mil_strobe_gen #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fclk,
  input  logic          wide,
  input  logic          cpu_we,
  input  logic [TW-1:0] tick,
  input  logic [1:0]    bank_en,
  output logic          ras_n,
  output logic [1:0]    cas_n,
  output logic          we_n,
  output logic          capture
);
  import mil_pkg::*;

  logic row_t, col_t;

  always_comb begin
    row_t   = run && (tick == TW'(ROW_TICK));
    col_t   = run && (tick == TW'(CAS_FIRST) || tick == TW'(CAP_TICK));
    ras_n   = ~(row_t | col_t);
    cas_n   = col_t ? ~bank_en : 2'b11;
    we_n    = ~(col_t && !fclk && cpu_we);
    capture = run && (tick == TW'(CAP_TICK));
  end

  // R4: writes only from the processor, only when asked
  assert_we_cpu_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!fclk && cpu_we && !ras_n));
  // R3: column strobe always inside an open row, precharge at the tail
  assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11) |-> !ras_n);
  assert_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick >= TW'(PRE_TICK)) |-> (ras_n && cas_n == 2'b11 && we_n));
  // R5: single bank unless a wide video slot
  assert_one_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fclk || !wide) |-> ($countones(~cas_n) <= 1));
  // R9: every slot opens a row before any column
  assert_row_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick == TW'(ROW_TICK)) |-> (!ras_n && cas_n == 2'b11));
endmodule

// File: rtl/mil_capture.sv
module mil_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          fclk,
  input  logic          cpu_we,
  input  logic          wide,
  input  logic [1:0]    bank_en,
  input  logic [2*DW-1:0] dq_i,
  output logic [DW-1:0]   cpu_rdata,
  output logic [2*DW-1:0] vid_rdata
);
  logic [DW-1:0]   cpu_q, cpu_d;
  logic [2*DW-1:0] vid_q, vid_d;
  logic [DW-1:0]   sel_byte;
  logic            cpu_en, vid_en;

  always_comb begin
    sel_byte = bank_en[1] ? dq_i[2*DW-1:DW] : dq_i[DW-1:0];
    cpu_en   = capture && !fclk && !cpu_we;
    vid_en   = capture && fclk;
    cpu_d    = sel_byte;
    vid_d    = wide ? dq_i : {{DW{1'b0}}, sel_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= '0;
      vid_q <= '0;
    end else begin
      if (cpu_en) cpu_q <= cpu_d;
      if (vid_en) vid_q <= vid_d;
    end
  end

  assign cpu_rdata = cpu_q;
  assign vid_rdata = vid_q;

  // R8: processor latch never moves during a video slot
  assert_cpu_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fclk |=> $stable(cpu_q));
  // R6: video data never moves during a processor slot
  assert_vid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fclk |=> $stable(vid_q));
endmodule

// File: rtl/vidcpu_interleave_arb.sv
module vidcpu_interleave_arb #(
  parameter int RW         = 4,
  parameter int DW         = 8,
  parameter int SLOT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*RW:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [2*RW:0]     vid_addr,
  input  logic              wide_mode,
  output logic              fclk_o,
  output logic [RW-1:0]     dram_a,
  output logic              dram_ras_n,
  output logic [1:0]        dram_cas_n,
  output logic              dram_we_n,
  output logic [DW-1:0]     dram_dq_o,
  input  logic [2*DW-1:0]   dram_dq_i,
  output logic [DW-1:0]     cpu_rdata,
  output logic [2*DW-1:0]   vid_rdata
);
  localparam int TW = $clog2(SLOT_TICKS);

  logic          rst_sync_n;
  logic          run;
  logic [TW-1:0] tick;
  logic          fclk;
  logic [1:0]    bank_en;
  logic          capture;

  mil_slot_timer #(.SLOT_TICKS(SLOT_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
    .run(run), .tick(tick), .fclk(fclk)
  );

  mil_addr_mux #(.RW(RW), .TW(TW)) mux_i (
    .fclk(fclk), .tick(tick), .wide(wide_mode),
    .cpu_addr(cpu_addr), .vid_addr(vid_addr),
    .dram_a(dram_a), .bank_en(bank_en)
  );

  mil_strobe_gen #(.TW(TW)) strobe_i (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .fclk(fclk),
    .wide(wide_mode), .cpu_we(cpu_we), .tick(tick), .bank_en(bank_en),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .capture(capture)
  );

  mil_capture #(.DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_sync_n), .capture(capture), .fclk(fclk),
    .cpu_we(cpu_we), .wide(wide_mode), .bank_en(bank_en),
    .dq_i(dram_dq_i), .cpu_rdata(cpu_rdata), .vid_rdata(vid_rdata)
  );

  assign fclk_o    = fclk;
  assign dram_dq_o = cpu_wdata;

  // R10: quiet array while reset is held
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sync_n |-> (dram_ras_n && dram_cas_n == 2'b11 && dram_we_n));
endmodule

// File: tb/vidcpu_interleave_arb_tb_top.sv
module vidcpu_interleave_arb_tb_top;
  localparam int RW = 4;
  localparam int DW = 8;
  localparam int AW = 2 * RW + 1;
  localparam int DEPTH = 1 << (2 * RW);
  localparam int NVEC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [AW-1:0]   cpu_addr, vid_addr;
  logic            cpu_we, wide_mode;
  logic [DW-1:0]   cpu_wdata;
  logic            fclk_o, dram_ras_n, dram_we_n;
  logic [RW-1:0]   dram_a;
  logic [1:0]      dram_cas_n;
  logic [DW-1:0]   dram_dq_o, cpu_rdata;
  logic [2*DW-1:0] dram_dq_i, vid_rdata;

  vidcpu_interleave_arb #(.RW(RW), .DW(DW), .SLOT_TICKS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .vid_addr(vid_addr), .wide_mode(wide_mode),
    .fclk_o(fclk_o), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_o(dram_dq_o),
    .dram_dq_i(dram_dq_i), .cpu_rdata(cpu_rdata), .vid_rdata(vid_rdata)
  );

  // behavioural two-bank DRAM
  logic [DW-1:0] mem [2][DEPTH];
  logic [RW-1:0] row_q;
  logic          ras_prev;

  function automatic logic [DW-1:0] pat(input int b, input int i);
    return DW'(i) ^ (b != 0 ? 8'hA5 : 8'h3C);
  endfunction

  assign dram_dq_i = {(!dram_cas_n[1] ? mem[1][{row_q, dram_a}] : 8'h00),
                      (!dram_cas_n[0] ? mem[0][{row_q, dram_a}] : 8'h00)};

  always @(posedge clk) begin
    ras_prev <= dram_ras_n;
    if (!dram_ras_n && ras_prev) row_q <= dram_a;
    for (int b = 0; b < 2; b++)
      if (!dram_cas_n[b] && !dram_we_n) mem[b][{row_q, dram_a}] <= dram_dq_o;
  end

  // expected contents, kept from the requirements alone
  logic [DW-1:0] exp_mem [2][DEPTH];

  // vector: wide, we, cpu_addr, wdata, vid_addr
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 9'h012, 8'h00, 9'h045},
    {1'b1, 1'b1, 9'h012, 8'h5A, 9'h0A2},
    {1'b0, 1'b0, 9'h012, 8'h00, 9'h013},
    {1'b1, 1'b0, 9'h1FF, 8'h00, 9'h1FE},
    {1'b0, 1'b1, 9'h1FF, 8'hC3, 9'h000},
    {1'b0, 1'b0, 9'h1FF, 8'h00, 9'h1FF},
    {1'b1, 1'b0, 9'h000, 8'h00, 9'h1FF},
    {1'b1, 1'b1, 9'h001, 8'h77, 9'h001}
  };

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_main();
    logic [DW-1:0]   exp_cpu;
    logic [2*DW-1:0] exp_vid;
    logic [1:0]      mask;
    rst_n = 1'b0; cpu_addr = '0; vid_addr = '0; cpu_we = 1'b0;
    cpu_wdata = '0; wide_mode = 1'b0;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(dram_ras_n === 1'b1, "R10 ras_n", 16'(dram_ras_n), 16'h1);
    check(dram_cas_n === 2'b11, "R10 cas_n", 16'(dram_cas_n), 16'h3);
    check(dram_we_n === 1'b1, "R10 we_n", 16'(dram_we_n), 16'h1);
    check(fclk_o === 1'b0, "R10 fclk", 16'(fclk_o), 16'h0);
    check(cpu_rdata === 8'h00, "R10 cpu_rdata", 16'(cpu_rdata), 16'h0);
    check(vid_rdata === 16'h0, "R10 vid_rdata", vid_rdata, 16'h0);
    rst_n = 1'b1;
    // lock on to the start of a processor slot
    do @(negedge clk); while (fclk_o !== 1'b1);
    do @(negedge clk); while (fclk_o !== 1'b0);
    exp_cpu = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      logic          w, we;
      logic [AW-1:0] ca, va;
      logic [DW-1:0] wd;
      {w, we, ca, wd, va} = VEC[v];
      // processor slot, tick 0
      wide_mode = w; cpu_we = we; cpu_addr = ca; cpu_wdata = wd; vid_addr = va;
      #1;
      check(fclk_o === 1'b0, "R1 cpu slot level", 16'(fclk_o), 16'h0);
      check(dram_a === ca[2*RW:RW+1] && dram_ras_n === 1'b0,
            "R2 cpu row", 16'(dram_a), 16'(ca[2*RW:RW+1]));
      @(negedge clk); // tick 1
      mask = ca[0] ? 2'b01 : 2'b10;
      check(dram_a === ca[RW:1], "R2 cpu column", 16'(dram_a), 16'(ca[RW:1]));
      check(dram_cas_n === mask, "R5 cpu single bank", 16'(dram_cas_n), 16'(mask));
      check(dram_we_n === ~we, "R4 cpu write enable", 16'(dram_we_n), 16'(~we));
      @(negedge clk); // tick 2
      @(negedge clk); // tick 3
      check(dram_ras_n === 1'b1 && dram_cas_n === 2'b11, "R3 precharge",
            16'({dram_ras_n, dram_cas_n}), 16'h7);
      if (we) exp_mem[ca[0]][ca[AW-1:1]] = wd;
      else    exp_cpu = exp_mem[ca[0]][ca[AW-1:1]];
      check(cpu_rdata === exp_cpu, "R8 cpu read data", 16'(cpu_rdata), 16'(exp_cpu));
      @(negedge clk); // video tick 0
      check(fclk_o === 1'b1, "R1 video slot level", 16'(fclk_o), 16'h1);
      check(dram_a === va[2*RW:RW+1] && dram_ras_n === 1'b0,
            "R9 video row opened", 16'(dram_a), 16'(va[2*RW:RW+1]));
      @(negedge clk); // video tick 1
      mask = w ? 2'b00 : (va[0] ? 2'b01 : 2'b10);
      check(dram_cas_n === mask, w ? "R6 both banks" : "R5 video single bank",
            16'(dram_cas_n), 16'(mask));
      check(dram_we_n === 1'b1, "R4 video never writes", 16'(dram_we_n), 16'h1);
      @(negedge clk); // video tick 2
      @(negedge clk); // video tick 3
      if (w) exp_vid = {exp_mem[1][va[AW-1:1]], exp_mem[0][va[AW-1:1]]};
      else   exp_vid = {8'h00, exp_mem[va[0]][va[AW-1:1]]};
      check(vid_rdata === exp_vid, w ? "R6 wide video data" : "R7 normal video data",
            vid_rdata, exp_vid);
      @(negedge clk); // next processor tick 0
    end
    // R8 directed: old read value held until the new capture
    cpu_we = 1'b0; cpu_addr = 9'h013; wide_mode = 1'b0;
    for (int t = 0; t < 3; t++) begin
      #1;
      check(cpu_rdata === exp_cpu, "R8 held into next slot", 16'(cpu_rdata), 16'(exp_cpu));
      @(negedge clk);
    end
    exp_cpu = exp_mem[1][8'h09];
    check(cpu_rdata === exp_cpu, "R8 new capture", 16'(cpu_rdata), 16'(exp_cpu));
  endtask

  initial begin
    ras_prev = 1'b1;
    row_q = '0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        mem[b][i] = pat(b, i);
        exp_mem[b][i] = pat(b, i);
      end
    fork
      run_main();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule